// File: doc/BRIEF.md
# Directed Mantissa Rounder

This block rounds a wide binary significand that carries two extra low-order bits, a guard bit above a round bit, together with a separately supplied sticky bit that summarises everything shifted out further below. It drops the two extra bits. Depending on a 2-bit direction code and the operand's sign, it either keeps the truncated value or adds one at its least significant position. It also reports whether any precision was lost and whether the increment was taken.

A floating-point datapath places it after alignment or normalisation and before exponent adjustment and packing. The caller provides headroom above the leading one. An increment that carries out of the top fraction bit is left in the result, so a value of 2.0 comes back for the caller to renormalise. A parameter selects a zero-latency combinational variant or a variant with one output register stage.

Top module: `mant_round_unit`

## Requirements
- R1: `mant_out` equals `mant_in[IN_W-1:2]` plus one when `rnd_up` is high, and plus zero otherwise. The sum is taken modulo 2^(IN_W-2). The guard bit (`mant_in[1]`) and round bit (`mant_in[0]`) are always discarded.
- R2: When guard, round and sticky are all zero, the result is exact. `inexact` and `rnd_up` are both low, and `mant_out` is the plain truncation.
- R3: With `mode_in` = 0 (nearest, ties to even), `rnd_up` is high only when guard is set and at least one of round, sticky or `mant_in[2]` is set. A guard-only tie therefore rounds up an odd value and keeps an even one.
- R4: With `mode_in` = 1 (toward zero), `rnd_up` is never high.
- R5: With `mode_in` = 2 (toward plus infinity), `rnd_up` is high exactly when the result is inexact and `sign_in` is 0.
- R6: With `mode_in` = 3 (toward minus infinity), `rnd_up` is high exactly when the result is inexact and `sign_in` is 1.
- R7: `inexact` is high exactly when any of guard, round or sticky is set, whatever the mode.
- R8: `rnd_up` is never high while `inexact` is low.
- R9: With REGISTERED = 1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge and hold between edges. While `rst_n` is low, all outputs are zero. With REGISTERED = 0, the outputs follow the inputs in the same cycle.
- R10: The increment carries across the whole result width. For example, 0x0000FFFF becomes 0x00010000. An all-ones result wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| mant_in | input | IN_W | Significand; bit 1 is guard and bit 0 is round |
| sign_in | input | 1 | Operand sign, 1 = negative |
| sticky_in | input | 1 | OR of all bits below the round bit |
| mode_in | input | 2 | Direction: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_out | output | IN_W-2 | Rounded significand |
| inexact | output | 1 | Precision was lost |
| rnd_up | output | 1 | The increment was applied |

## Verification
A bound checker holds on every cycle the relations between flags and inputs. It checks the exact case, inexactness, the direction rules for each mode, and the link between the up flag and inexactness. It also checks that the output value is the truncated input plus the up flag, using inputs it has delayed itself. Only the bench's scenarios show the zero state during reset and the one-cycle latency with held outputs. The same holds for ties-to-even on chosen odd and even values, long carry chains and the wrap of an all-ones value, which it checks against a scoreboard with an independent model.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_TO_ZERO = 2'd1,
      RND_TO_POS  = 2'd2,
      RND_TO_NEG  = 2'd3
   } rnd_dir_e;

   // Number of chunks needed to cover a vector of w bits
   function automatic int chunk_count(input int w, input int cw);
      return (w + cw - 1) / cw;
   endfunction

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
   import mant_round_pkg::*;
(
   input  logic     guard_bit,
   input  logic     round_bit,
   input  logic     sticky_bit,
   input  logic     lsb_bit,
   input  logic     sign_bit,
   input  rnd_dir_e dir,
   output logic     lost,
   output logic     bump
);

   always_comb begin
      lost = guard_bit | round_bit | sticky_bit;
      bump = 1'b0;
      unique case (dir)
         RND_NEAREST: bump = guard_bit & (round_bit | sticky_bit | lsb_bit);
         RND_TO_ZERO: bump = 1'b0;
         RND_TO_POS:  bump = lost & ~sign_bit;
         RND_TO_NEG:  bump = lost & sign_bit;
         default:     bump = 1'b0;
      endcase
   end

endmodule

// File: rtl/mant_round_incr.sv
module mant_round_incr
   import mant_round_pkg::*;
#(
   parameter int W       = 32,
   parameter int CHUNK_W = 8
) (
   input  logic [W-1:0] val_in,
   input  logic         inc,
   output logic [W-1:0] val_out
);

   localparam int NCH   = chunk_count(W, CHUNK_W);
   localparam int PAD_W = NCH * CHUNK_W;

   logic [PAD_W-1:0] padded;
   logic [PAD_W-1:0] summed;
   logic [NCH-1:0]   carry;

   assign padded   = PAD_W'(val_in);
   assign carry[0] = inc;

   // Each chunk adds its incoming carry; a chunk passes the carry on only when it is all ones
   for (genvar k = 0; k < NCH; k++) begin : g_chunk
      assign summed[k*CHUNK_W +: CHUNK_W] =
         padded[k*CHUNK_W +: CHUNK_W] + CHUNK_W'(carry[k]);
      if (k < NCH - 1) begin : g_prop
         assign carry[k+1] = carry[k] & (&padded[k*CHUNK_W +: CHUNK_W]);
      end
   end

   assign val_out = summed[W-1:0];

endmodule

// File: rtl/mant_round_stage.sv
module mant_round_stage #(
   parameter int W          = 34,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      assign q = d;
   end

endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
   import mant_round_pkg::*;
#(
   parameter int IN_W       = 34,
   parameter int CHUNK_W    = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IN_W-1:0]   mant_in,
   input  logic              sign_in,
   input  logic              sticky_in,
   input  logic [1:0]        mode_in,
   output logic [IN_W-3:0]   mant_out,
   output logic              inexact,
   output logic              rnd_up
);

   localparam int OUT_W = IN_W - 2;
   localparam int BUS_W = OUT_W + 2;

   if (IN_W < 4) begin : g_bad_width
      $error("mant_round_unit: IN_W must be at least 4");
   end
   if (CHUNK_W < 1 || CHUNK_W > OUT_W) begin : g_bad_chunk
      $error("mant_round_unit: CHUNK_W must lie in 1..IN_W-2");
   end

   logic [OUT_W-1:0] trunc;
   logic [OUT_W-1:0] bumped;
   logic             lost;
   logic             bump;
   logic [BUS_W-1:0] res_d;
   logic [BUS_W-1:0] res_q;

   assign trunc = mant_in[IN_W-1:2];

   mant_round_decide u_decide (
      .guard_bit  (mant_in[1]),
      .round_bit  (mant_in[0]),
      .sticky_bit (sticky_in),
      .lsb_bit    (mant_in[2]),
      .sign_bit   (sign_in),
      .dir        (rnd_dir_e'(mode_in)),
      .lost       (lost),
      .bump       (bump)
   );

   mant_round_incr #(.W(OUT_W), .CHUNK_W(CHUNK_W)) u_incr (
      .val_in  (trunc),
      .inc     (bump),
      .val_out (bumped)
   );

   assign res_d = {bumped, lost, bump};

   mant_round_stage #(.W(BUS_W), .REGISTERED(REGISTERED)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (res_d),
      .q     (res_q)
   );

   assign mant_out = res_q[BUS_W-1:2];
   assign inexact  = res_q[1];
   assign rnd_up   = res_q[0];

endmodule

// File: rtl/mant_round_unit_chk.sv
module mant_round_unit_chk #(
   parameter int IN_W       = 34,
   parameter bit REGISTERED = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [IN_W-1:0] mant_in,
   input logic            sign_in,
   input logic            sticky_in,
   input logic [1:0]      mode_in,
   input logic [IN_W-3:0] mant_out,
   input logic            inexact,
   input logic            rnd_up
);

   logic [IN_W-1:0] m_d;
   logic            s_d, st_d, ready;
   logic [1:0]      md_d;

   if (REGISTERED) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_d <= '0; s_d <= 1'b0; st_d <= 1'b0; md_d <= 2'd0; ready <= 1'b0;
         end else begin
            m_d <= mant_in; s_d <= sign_in; st_d <= sticky_in; md_d <= mode_in; ready <= 1'b1;
         end
      end
   end else begin : g_now
      assign m_d = mant_in; assign s_d = sign_in; assign st_d = sticky_in;
      assign md_d = mode_in; assign ready = 1'b1;
   end

   logic any_lost;
   assign any_lost = m_d[1] | m_d[0] | st_d;

   // R1 R10
   value_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> mant_out == m_d[IN_W-1:2] + (IN_W-2)'(rnd_up));

   // R2
   exact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !any_lost) |-> (!inexact && !rnd_up));

   // R3
   near_guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && md_d == 2'd0 && !m_d[1]) |-> !rnd_up);

   // R3
   near_above_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && md_d == 2'd0 && m_d[1] && (m_d[0] || st_d)) |-> rnd_up);

   // R4
   zero_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && md_d == 2'd1) |-> !rnd_up);

   // R5
   pos_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && md_d == 2'd2) |-> (rnd_up == (any_lost && !s_d)));

   // R6
   neg_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && md_d == 2'd3) |-> (rnd_up == (any_lost && s_d)));

   // R7
   lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (inexact == any_lost));

   // R8
   up_needs_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_up |-> inexact);

endmodule

bind mant_round_unit mant_round_unit_chk #(.IN_W(IN_W), .REGISTERED(REGISTERED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mant_in   (mant_in),
   .sign_in   (sign_in),
   .sticky_in (sticky_in),
   .mode_in   (mode_in),
   .mant_out  (mant_out),
   .inexact   (inexact),
   .rnd_up    (rnd_up)
);

// File: tb/mant_round_unit_test.sv
module mant_round_unit_test;

   localparam int IN_W  = 34;
   localparam int OUT_W = IN_W - 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [IN_W-1:0]   mant_in = '0;
   logic              sign_in = 1'b0;
   logic              sticky_in = 1'b0;
   logic [1:0]        mode_in = 2'd0;
   logic [OUT_W-1:0]  mant_out;
   logic              inexact;
   logic              rnd_up;

   always #2 clk = ~clk;   // 250 MHz

   mant_round_unit #(.IN_W(IN_W)) uut (
      .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sign_in(sign_in),
      .sticky_in(sticky_in), .mode_in(mode_in),
      .mant_out(mant_out), .inexact(inexact), .rnd_up(rnd_up)
   );

   typedef struct {
      logic [OUT_W-1:0] m;
      logic             nx;
      logic             up;
      string            tag;
   } exp_t;

   exp_t sb[$];
   int   checks = 0;
   int   fails  = 0;
   bit   finished = 1'b0;

   function automatic exp_t model(input logic [OUT_W-1:0] frac, input logic g, input logic r,
                                  input logic s, input logic neg, input logic [1:0] md,
                                  input string tag);
      exp_t e;
      e.nx = g | r | s;
      case (md)
         2'd0:    e.up = g && (r || s || frac[0]);
         2'd1:    e.up = 1'b0;
         2'd2:    e.up = e.nx && !neg;
         default: e.up = e.nx && neg;
      endcase
      e.m   = frac + OUT_W'(e.up);
      e.tag = tag;
      return e;
   endfunction

   task automatic drive(input logic [OUT_W-1:0] frac, input logic g, input logic r,
                        input logic s, input logic neg, input logic [1:0] md, input string tag);
      @(negedge clk);
      mant_in   = {frac, g, r};
      sticky_in = s;
      sign_in   = neg;
      mode_in   = md;
      sb.push_back(model(frac, g, r, s, neg, md, tag));
   endtask

   // Monitor: one result per cycle, sampled just after the capturing edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (mant_out !== e.m || inexact !== e.nx || rnd_up !== e.up) begin
               fails++;
               $display("FAIL %s: got m=%h nx=%b up=%b, expected m=%h nx=%b up=%b",
                        e.tag, mant_out, inexact, rnd_up, e.m, e.nx, e.up);
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R9: reset state with non-zero inputs present
      mant_in = '1; sticky_in = 1'b1; mode_in = 2'd2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (mant_out !== '0 || inexact !== 1'b0 || rnd_up !== 1'b0) begin
         fails++;
         $display("FAIL R9 reset: got m=%h nx=%b up=%b, expected all zero", mant_out, inexact, rnd_up);
      end
      rst_n = 1'b1;

      drive(32'h1234_5678, 0, 0, 0, 0, 2'd0, "R2 exact nearest");
      drive(32'h0000_0010, 1, 1, 0, 0, 2'd0, "R3 above half");
      drive(32'h0000_0010, 1, 0, 0, 0, 2'd0, "R3 tie even kept");
      drive(32'h0000_0011, 1, 0, 0, 1, 2'd0, "R3 tie odd up");
      drive(32'h0000_0010, 1, 0, 1, 0, 2'd0, "R3 guard+sticky up");
      drive(32'h0000_0011, 0, 1, 1, 0, 2'd0, "R3 below half");
      drive(32'h0000_0011, 1, 1, 1, 1, 2'd1, "R4 toward zero");
      drive(32'h0000_0020, 0, 0, 1, 0, 2'd2, "R5 plus inf positive");
      drive(32'h0000_0020, 1, 1, 0, 1, 2'd2, "R5 plus inf negative");
      drive(32'h0000_0020, 0, 1, 0, 1, 2'd3, "R6 minus inf negative");
      drive(32'h0000_0020, 1, 0, 1, 0, 2'd3, "R6 minus inf positive");
      drive(32'hABCD_0001, 0, 0, 0, 1, 2'd3, "R7 R8 exact minus inf");
      drive(32'h7FFF_FFFF, 0, 0, 0, 0, 2'd2, "R2 exact plus inf");
      drive(32'h0000_FFFF, 1, 0, 0, 0, 2'd2, "R10 carry chain");
      drive(32'h7FFF_FFFF, 0, 0, 1, 1, 2'd3, "R10 carry to top");
      drive(32'hFFFF_FFFF, 1, 1, 0, 0, 2'd0, "R10 wrap to zero");

      // R9: between edges the output still shows the previous result
      drive(32'h0000_0005, 0, 0, 0, 0, 2'd1, "R1 hold setup");
      drive(32'h0000_0099, 1, 1, 1, 0, 2'd2, "R1 next value");
      #1;
      checks++;
      if (mant_out !== 32'h0000_0005) begin
         fails++;
         $display("FAIL R9 hold: got m=%h, expected m=%h", mant_out, 32'h0000_0005);
      end

      // R1 R3 R5 R6 R7: broad mixed patterns
      for (int i = 0; i < 400; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         drive($urandom, rv[0], rv[1], rv[2], rv[3], rv[5:4], "R1 mixed");
      end

      repeat (3) @(posedge clk);
      #1;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule